// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Table

This block holds the routing configuration for a set of interrupt input lines, one wide entry per line. Each entry carries the interrupt vector, the delivery mode, the destination mode, the input polarity, the trigger mode, a mask bit and an 8-bit destination set. The fields of every entry drive dedicated per-line output ports, so the logic that formats and sends interrupt messages can read them without going through the bus.

Software never addresses the table directly. The block's 32-bit bus slave has two locations. A selector register at bus address 0x00 takes an 8-bit register number. A data window at bus address 0x10 then reads or writes the register that number selects. Register number 0x00 is an identification register and 0x01 is a read-only version register. From register number 0x10 upward, each line's 64-bit entry takes two consecutive numbers, the low word first.

Top module: `irq_route_table`

## Requirements
- R1: After reset every entry has its mask bit set and all other bits zero. Every low word therefore reads 0x0001_0000, every high word reads 0, all `line_mask` bits are 1, and all other line outputs are 0.
- R2: A write to bus address 0x00 loads the selector from write data bits 7:0. A read of 0x00 returns the selector in bits 7:0, with bits 31:8 reading as zero.
- R3: Through the window, the low word of an entry is writable in these bits: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, trigger mode 15 and mask 16. Bits 12 and 14 are read-only zero and all other bits read as zero, so writing 0xFFFF_FFFF reads back 0x0001_AFFF. Each field drives the matching line output.
- R4: The high word holds the 8-bit destination in bits 31:24, which drives `line_dest`. Its other bits read as zero, so writing 0xFFFF_FFFF reads back 0xFF00_0000.
- R5: The low word of line n is register number 0x10+2n and the high word is 0x10+2n+1. A write changes only the selected word of the selected line.
- R6: Register number 0x01 reads as (N_LINES-1) in bits 23:16 and the version constant 0x20 in bits 7:0. With 24 lines this is 0x0017_0020. Writes to it are ignored.
- R7: Register number 0x00 holds a writable 4-bit identifier in bits 27:24. Its other bits read as zero, so writing 0xFFFF_FFFF reads back 0x0F00_0000.
- R8: A selector value that names no register (0x02 to 0x0F, and 0x10+2*N_LINES to 0xFF) reads as zero through the window. Writes to it change no register and no output.
- R9: Bus addresses other than 0x00 and 0x10 read as zero, and writes to them change neither the selector nor any register.
- R10: A window write becomes visible on the line outputs at the first clock edge after the write is presented, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Bus byte address (0x00 selector, 0x10 window) |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address and state |
| line_vector | output | 8*N_LINES | Vector per line, line n at [8n+7:8n] |
| line_dlv_mode | output | 3*N_LINES | Delivery mode per line (0 fixed, 1 lowest priority) |
| line_dest_mode | output | N_LINES | Destination mode per line (1 logical) |
| line_polarity | output | N_LINES | 1 selects an active-low input |
| line_trigger | output | N_LINES | 1 selects level trigger, 0 edge trigger |
| line_mask | output | N_LINES | 1 masks the line |
| line_dest | output | 8*N_LINES | Destination set per line (0xFF means all) |

## Verification
The hardest case to reach is a window write whose selector is left over from an earlier access: the selector is sticky, so the bench must show that a write to an unmapped number, or to the version register, lands nowhere. The scoreboard model tracks the selector and every entry word. After each such stray write, the bench reads the neighbouring entries back and compares every line output against the model. The boundary entries (line 0 and the last line) and the numbers just outside the table are driven on purpose.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;

    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] dlv_mode;
        logic       dest_mode;
        logic       polarity;
        logic       trigger;
        logic       mask;
        logic [7:0] dest;
    } rt_entry_t;

    // low word bit positions
    localparam int VEC_LSB  = 0;
    localparam int DLV_LSB  = 8;
    localparam int DMOD_BIT = 11;
    localparam int POL_BIT  = 13;
    localparam int TRIG_BIT = 15;
    localparam int MASK_BIT = 16;
    // high word bit position
    localparam int DEST_LSB = 24;

    localparam rt_entry_t ENTRY_RESET = '{mask: 1'b1, default: '0};

    function automatic logic [31:0] pack_lo(rt_entry_t e);
        logic [31:0] w;
        w = '0;
        w[VEC_LSB +: 8] = e.vector;
        w[DLV_LSB +: 3] = e.dlv_mode;
        w[DMOD_BIT]     = e.dest_mode;
        w[POL_BIT]      = e.polarity;
        w[TRIG_BIT]     = e.trigger;
        w[MASK_BIT]     = e.mask;
        return w;
    endfunction

    function automatic logic [31:0] pack_hi(rt_entry_t e);
        logic [31:0] w;
        w = '0;
        w[DEST_LSB +: 8] = e.dest;
        return w;
    endfunction

endpackage

// File: rtl/irq_rt_decode.sv
module irq_rt_decode #(
    parameter int          N_LINES  = 24,
    parameter logic [7:0]  TBL_BASE = 8'h10,
    localparam int         LW       = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic [7:0]    sel,
    output logic          hit_id,
    output logic          hit_ver,
    output logic          hit_entry,
    output logic          hi_half,
    output logic [LW-1:0] line
);
    localparam logic [8:0] SPAN = 9'(2 * N_LINES);

    logic [7:0] off;

    always_comb begin
        off       = sel - TBL_BASE;
        hit_id    = (sel == 8'h00);
        hit_ver   = (sel == 8'h01);
        hit_entry = (sel >= TBL_BASE) && ({1'b0, off} < SPAN);
        hi_half   = off[0];
        line      = off[LW:1];
    end

endmodule

// File: rtl/irq_rt_entry.sv
module irq_rt_entry
    import irq_rt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    output rt_entry_t   ent,
    output logic [31:0] lo_word,
    output logic [31:0] hi_word
);
    rt_entry_t ent_d, ent_q;
    logic      unused_bits;

    assign unused_bits = ^{wdata[23:17], wdata[14], wdata[12]};

    always_comb begin
        ent_d = ent_q;
        if (wr_lo) begin
            ent_d.vector    = wdata[VEC_LSB +: 8];
            ent_d.dlv_mode  = wdata[DLV_LSB +: 3];
            ent_d.dest_mode = wdata[DMOD_BIT];
            ent_d.polarity  = wdata[POL_BIT];
            ent_d.trigger   = wdata[TRIG_BIT];
            ent_d.mask      = wdata[MASK_BIT];
        end
        if (wr_hi) begin
            ent_d.dest = wdata[DEST_LSB +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= ENTRY_RESET;
        else        ent_q <= ent_d;
    end

    assign ent     = ent_q;
    assign lo_word = pack_lo(ent_q);
    assign hi_word = pack_hi(ent_q);

    AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (ent_q.vector == $past(wdata[7:0])) && (ent_q.mask == $past(wdata[16]))
                  && (ent_q.trigger == $past(wdata[15]))); // R3
    AST_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> ent_q.dest == $past(wdata[31:24])); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi) |=> $stable(ent_q)); // R5

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
    import irq_rt_pkg::*;
#(
    parameter int         N_LINES  = 24,
    parameter logic [7:0] TBL_BASE = 8'h10,
    parameter logic [7:0] VERSION  = 8'h20,
    parameter int         ID_W     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [7:0]             bus_addr,
    input  logic                   bus_we,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    output logic [8*N_LINES-1:0]   line_vector,
    output logic [3*N_LINES-1:0]   line_dlv_mode,
    output logic [N_LINES-1:0]     line_dest_mode,
    output logic [N_LINES-1:0]     line_polarity,
    output logic [N_LINES-1:0]     line_trigger,
    output logic [N_LINES-1:0]     line_mask,
    output logic [8*N_LINES-1:0]   line_dest
);
    localparam int          LW       = (N_LINES > 1) ? $clog2(N_LINES) : 1;
    localparam logic [7:0]  SEL_ADDR = 8'h00;
    localparam logic [7:0]  WIN_ADDR = 8'h10;
    localparam logic [7:0]  MAX_IDX  = 8'(N_LINES - 1);
    localparam logic [31:0] VER_WORD = {8'h00, MAX_IDX, 8'h00, VERSION};
    localparam int          ID_LSB   = 24;

    typedef struct packed {
        logic [7:0]      index;
        logic [ID_W-1:0] id;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          hit_id, hit_ver, hit_entry, hi_half;
    logic [LW-1:0] line;
    logic          win_wr;
    logic [N_LINES-1:0] lo_wr_vec, hi_wr_vec;
    logic [31:0]   lo_words [N_LINES];
    logic [31:0]   hi_words [N_LINES];
    logic [31:0]   win_rdata;

    irq_rt_decode #(.N_LINES(N_LINES), .TBL_BASE(TBL_BASE)) u_decode (
        .sel      (ctl_q.index),
        .hit_id   (hit_id),
        .hit_ver  (hit_ver),
        .hit_entry(hit_entry),
        .hi_half  (hi_half),
        .line     (line)
    );

    assign win_wr = bus_we && (bus_addr == WIN_ADDR);

    // control registers: selector and identifier
    always_comb begin
        ctl_d = ctl_q;
        if (bus_we && (bus_addr == SEL_ADDR)) ctl_d.index = bus_wdata[7:0];
        if (win_wr && hit_id)                 ctl_d.id    = bus_wdata[ID_LSB +: ID_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        rt_entry_t ent;

        assign lo_wr_vec[g] = win_wr && hit_entry && (line == LW'(g)) && !hi_half;
        assign hi_wr_vec[g] = win_wr && hit_entry && (line == LW'(g)) &&  hi_half;

        irq_rt_entry u_entry (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_lo  (lo_wr_vec[g]),
            .wr_hi  (hi_wr_vec[g]),
            .wdata  (bus_wdata),
            .ent    (ent),
            .lo_word(lo_words[g]),
            .hi_word(hi_words[g])
        );

        assign line_vector[8*g +: 8]   = ent.vector;
        assign line_dlv_mode[3*g +: 3] = ent.dlv_mode;
        assign line_dest_mode[g]       = ent.dest_mode;
        assign line_polarity[g]        = ent.polarity;
        assign line_trigger[g]         = ent.trigger;
        assign line_mask[g]            = ent.mask;
        assign line_dest[8*g +: 8]     = ent.dest;
    end

    // read path
    always_comb begin
        win_rdata = '0;
        if (hit_id) begin
            win_rdata[ID_LSB +: ID_W] = ctl_q.id;
        end else if (hit_ver) begin
            win_rdata = VER_WORD;
        end else if (hit_entry) begin
            win_rdata = hi_half ? hi_words[line] : lo_words[line];
        end
        case (bus_addr)
            SEL_ADDR: bus_rdata = {24'h0, ctl_q.index};
            WIN_ADDR: bus_rdata = win_rdata;
            default:  bus_rdata = '0;
        endcase
    end

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == SEL_ADDR) |=> ctl_q.index == $past(bus_wdata[7:0])); // R2
    AST_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lo_wr_vec, hi_wr_vec})); // R5
    AST_VER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == WIN_ADDR && ctl_q.index == 8'h01) |-> bus_rdata[23:16] == MAX_IDX); // R6
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == WIN_ADDR && !hit_id && !hit_ver && !hit_entry) |-> bus_rdata == 32'h0); // R8
    AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != WIN_ADDR && bus_addr != SEL_ADDR) |-> bus_rdata == 32'h0); // R9
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !win_wr |-> ({lo_wr_vec, hi_wr_vec} == '0)); // R9

endmodule

// File: tb/irq_route_table_bench.sv
module irq_route_table_bench;
    localparam int N = 24;
    localparam logic [31:0] LO_MASK  = 32'h0001_AFFF;
    localparam logic [31:0] HI_MASK  = 32'hFF00_0000;
    localparam logic [31:0] ID_MASK  = 32'h0F00_0000;
    localparam logic [31:0] VER_WORD = 32'h0017_0020;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [8*N-1:0] line_vector, line_dest;
    logic [3*N-1:0] line_dlv_mode;
    logic [N-1:0]   line_dest_mode, line_polarity, line_trigger, line_mask;

    always #4 clk = ~clk;

    irq_route_table u_irq_route_table (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_vector(line_vector), .line_dlv_mode(line_dlv_mode),
        .line_dest_mode(line_dest_mode), .line_polarity(line_polarity),
        .line_trigger(line_trigger), .line_mask(line_mask), .line_dest(line_dest)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // model state
    logic [31:0] lo_m [N];
    logic [31:0] hi_m [N];
    logic [31:0] id_m;
    logic [7:0]  sel_m;

    typedef struct { logic [31:0] exp; string tag; } sb_item_t;
    sb_item_t sb [$];
    logic mon_req = 1'b0;

    task automatic check_eq(input logic [31:0] got, input logic [31:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor: pops expected read data while the window is being read
    always @(negedge clk) begin
        if (mon_req) begin
            sb_item_t it;
            it = sb.pop_front();
            check_eq(bus_rdata, it.exp, it.tag);
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] off);
        if (off == 8'h00) return id_m;
        if (off == 8'h01) return VER_WORD;
        if (off >= 8'h10 && int'(off) < 16 + 2 * N)
            return off[0] ? hi_m[(int'(off) - 16) / 2] : lo_m[(int'(off) - 16) / 2];
        return 32'h0;
    endfunction

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
        if (a == 8'h00) sel_m = d[7:0];
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        sb_item_t it;
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b0;
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
        mon_req = 1'b1;
        @(posedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] off, input logic [31:0] d);
        bus_wr(8'h00, {24'h0, off});
        bus_wr(8'h10, d);
        if (off == 8'h00) id_m = d & ID_MASK;
        else if (off >= 8'h10 && int'(off) < 16 + 2 * N) begin
            if (off[0]) hi_m[(int'(off) - 16) / 2] = d & HI_MASK;
            else        lo_m[(int'(off) - 16) / 2] = d & LO_MASK;
        end
    endtask

    task automatic reg_rd(input logic [7:0] off, input string tag);
        bus_wr(8'h00, {24'h0, off});
        bus_rd(8'h10, model_read(off), tag);
    endtask

    task automatic check_line(input int n, input string tag);
        check_eq({24'h0, line_vector[8*n +: 8]},  {24'h0, lo_m[n][7:0]},   {tag, " vector"});
        check_eq({29'h0, line_dlv_mode[3*n +: 3]}, {29'h0, lo_m[n][10:8]}, {tag, " dlv"});
        check_eq({31'h0, line_dest_mode[n]}, {31'h0, lo_m[n][11]}, {tag, " dmode"});
        check_eq({31'h0, line_polarity[n]},  {31'h0, lo_m[n][13]}, {tag, " pol"});
        check_eq({31'h0, line_trigger[n]},   {31'h0, lo_m[n][15]}, {tag, " trig"});
        check_eq({31'h0, line_mask[n]},      {31'h0, lo_m[n][16]}, {tag, " mask"});
        check_eq({24'h0, line_dest[8*n +: 8]}, {24'h0, hi_m[n][31:24]}, {tag, " dest"});
    endtask

    task automatic check_all_lines(input string tag);
        for (int n = 0; n < N; n++) check_line(n, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int n = 0; n < N; n++) begin lo_m[n] = 32'h0001_0000; hi_m[n] = 32'h0; end
        id_m = 32'h0; sel_m = 8'h0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check_all_lines("R1 reset");
        reg_rd(8'h10, "R1 lo line0");
        reg_rd(8'h11, "R1 hi line0");
        reg_rd(8'h3E, "R1 lo line23");

        // R2 selector readback
        bus_wr(8'h00, 32'hABCD_1234);
        bus_rd(8'h00, 32'h0000_0034, "R2 selector");

        // R6 version read, write ignored
        reg_rd(8'h01, "R6 version");
        reg_wr(8'h01, 32'hFFFF_FFFF);
        reg_rd(8'h01, "R6 version after write");

        // R7 identifier
        reg_wr(8'h00, 32'hFFFF_FFFF);
        reg_rd(8'h00, "R7 id all ones");
        reg_wr(8'h00, 32'h3500_00FF);
        reg_rd(8'h00, "R7 id pattern");

        // R3 low word fields and read-only bits
        reg_wr(8'h1A, 32'hFFFF_FFFF);
        reg_rd(8'h1A, "R3 lo line5 all ones");
        check_line(5, "R3 line5 ones");
        reg_wr(8'h1A, 32'h0000_A1C7);
        reg_rd(8'h1A, "R3 lo line5 pattern");
        check_line(5, "R3 line5 pattern");
        reg_wr(8'h10, 32'h0001_2930);
        check_line(0, "R3 line0");
        reg_wr(8'h3E, 32'h0000_09FE);
        reg_rd(8'h3E, "R3 lo line23");
        check_line(23, "R3 line23");

        // R4 high word
        reg_wr(8'h1B, 32'hFFFF_FFFF);
        reg_rd(8'h1B, "R4 hi line5 all ones");
        reg_wr(8'h3F, 32'h1234_5678);
        reg_rd(8'h3F, "R4 hi line23");
        check_line(23, "R4 line23");

        // R5 isolation of neighbours
        check_line(4, "R5 line4");
        check_line(6, "R5 line6");
        check_line(22, "R5 line22");

        // R8 unmapped selector values
        reg_wr(8'h02, 32'hFFFF_FFFF);
        reg_rd(8'h02, "R8 sel 02");
        reg_wr(8'h0F, 32'hFFFF_FFFF);
        reg_rd(8'h0F, "R8 sel 0F");
        reg_wr(8'h40, 32'hFFFF_FFFF);
        reg_rd(8'h40, "R8 sel 40");
        reg_wr(8'hFF, 32'hFFFF_FFFF);
        reg_rd(8'hFF, "R8 sel FF");
        check_all_lines("R8 lines untouched");
        reg_rd(8'h00, "R8 id untouched");

        // R9 other bus addresses
        bus_wr(8'h00, 32'h0000_0012);
        bus_wr(8'h04, 32'hFFFF_FFFF);
        bus_wr(8'h14, 32'hFFFF_FFFF);
        bus_rd(8'h04, 32'h0, "R9 addr 04 reads zero");
        bus_rd(8'h14, 32'h0, "R9 addr 14 reads zero");
        bus_rd(8'h00, 32'h0000_0012, "R9 selector unchanged");
        reg_rd(8'h12, "R9 line1 lo unchanged");
        check_all_lines("R9 lines untouched");

        // R10 write visible only after the clock edge
        bus_wr(8'h00, 32'h0000_001E);
        @(posedge clk); #1;
        bus_addr = 8'h10; bus_we = 1'b1; bus_wdata = 32'h0000_0155;
        check_eq({24'h0, line_vector[8*7 +: 8]}, 32'h0, "R10 before edge");
        check_eq({31'h0, line_mask[7]}, 32'h1, "R10 mask before edge");
        @(posedge clk); #1;
        bus_we = 1'b0;
        lo_m[7] = 32'h0000_0155 & LO_MASK;
        check_eq({24'h0, line_vector[8*7 +: 8]}, 32'h55, "R10 after edge");
        check_line(7, "R10 line7");

        // R5 final sweep of every line
        check_all_lines("R5 final");
        @(posedge clk); #1;
        check_eq(32'(sb.size()), 32'h0, "scoreboard drained");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule